// File: doc/BRIEF.md
# Load Result Formatter

This block sits after the data return path of a load and turns the raw bytes fetched from memory into the value or values to be written into the destination register file. It handles item sizes of one, two, four, eight and sixteen bytes and applies one of three treatments to the loaded item: clearing the upper bits, filling them with copies of the item's top bit, or reversing the byte order before clearing. A sixteen-byte load fills a pair of registers, and the endian mode decides which half goes where and whether each half is byte-swapped.

The raw input is 128 bits wide. The byte at the base address sits in `in_data[127:120]`, the byte at base+1 in `in_data[119:112]`, and so on down to base+15 in `in_data[7:0]`. An item of n bytes is read as a big-endian number whose most significant byte is the one at the base address. Register bit 0 in the architectural numbering, which is the most significant bit, is `out_even[63]`, and bit 63 is `out_even[0]`. The block has one register stage: a request presented with `in_vld` high produces its result one clock later, qualified by `out_vld`. When `in_vld` is low, the outputs hold their previous value.

Top module: `ldx_unit`

## Requirements
- R1: After reset, `out_vld`, `out_pair` and `out_bad` are 0 and both result words are 0. A request accepted on a clock edge with `in_vld`=1 shows up at the next edge with `out_vld`=1. `out_vld` is 0 after any edge where `in_vld` was 0, and the result outputs then hold their previous values.
- R2: Size code 0 (byte) puts the byte at the base address into `out_even[7:0]` and clears `out_even[63:8]`.
- R3: Size code 1 (halfword) with the sign flag 0 puts the two bytes into `out_even[15:0]` and clears `out_even[63:16]`. Size code 2 (word) with the sign flag 0 puts the four bytes into `out_even[31:0]` and clears `out_even[63:32]`.
- R4: With `in_sext`=1, a halfword or word load copies the item's most significant bit (`out_even[15]` for a halfword, `out_even[31]` for a word) into every bit above the item.
- R5: With `in_brev`=1, a halfword or word load reverses the order of the item's bytes, so the base-address byte becomes the least significant one. The upper bits are then cleared.
- R6: Size code 3 (doubleword) without reversal passes the eight base bytes through unchanged. With `in_brev`=1, all eight bytes are reversed.
- R7: Size code 4 (quadword) with `in_le`=0 puts bytes base..base+7 into `out_even` and bytes base+8..base+15 into `out_odd`, each as a big-endian number, and sets `out_pair`.
- R8: Size code 4 with `in_le`=1 puts the byte-reversed doubleword from base+8 into `out_even` and the byte-reversed doubleword from the base into `out_odd`, and sets `out_pair`.
- R9: Except for size code 4, `out_pair` is 0, `out_odd` is 0, and `in_le` has no effect on the result.
- R10: These requests set `out_bad`=1 and drive both result words to 0: `in_sext`=1 with size byte, doubleword or quadword; `in_sext`=1 together with `in_brev`=1; `in_brev`=1 with size byte or quadword; and size codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request present this cycle |
| in_data | input | 128 | Raw bytes; the base-address byte is in bits 127:120 |
| in_size | input | 3 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword, 4 quadword |
| in_sext | input | 1 | Fill the upper bits with the item's top bit |
| in_brev | input | 1 | Reverse the item's bytes |
| in_le | input | 1 | Endian mode for quadword loads (1 = little) |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_even | output | 64 | Single result, or the even register of a pair |
| out_odd | output | 64 | Odd register of a pair, 0 otherwise |
| out_pair | output | 1 | Result fills a register pair |
| out_bad | output | 1 | Unsupported combination; results forced to 0 |

## Verification
The main function is tried with data whose bytes all differ, so that any wrong byte lane or wrong order changes the result. The same patterns are applied with the top bit of the base byte set and with it clear, which separates sign filling from zero clearing. Each quadword pattern is sent in both endian modes, and non-quadword sizes are sent with `in_le` toggled; this shows the mode changes only the pair layout. Every illegal flag and size combination is sent after a legal request with non-zero data, so a forced zero cannot be confused with a stale value.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int REG_W     = 64;
  localparam int REG_BYTES = REG_W / 8;
  localparam int RAW_W     = 2 * REG_W;
  localparam int SIZE_W    = 3;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_QUAD  = 3'd4
  } size_e;

  typedef logic [REG_W-1:0] reg_t;

  // number of bytes in a single-register item; 0 for quad or illegal codes
  function automatic int item_bytes(input logic [SIZE_W-1:0] s);
    case (s)
      SZ_BYTE:  return 1;
      SZ_HALF:  return 2;
      SZ_WORD:  return 4;
      SZ_DWORD: return REG_BYTES;
      default:  return 0;
    endcase
  endfunction

  // reverse the low n bytes of v, clearing everything above them
  function automatic reg_t rev_low_bytes(input reg_t v, input int n);
    reg_t r;
    r = '0;
    for (int i = 0; i < REG_BYTES; i++) begin
      if (i < n) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    end
    return r;
  endfunction

  // keep the low n bytes of v and copy bit 8n-1 into all higher bits
  function automatic reg_t fill_sign(input reg_t v, input int n);
    reg_t r;
    logic top;
    top = v[8*n-1];
    for (int b = 0; b < REG_W; b++) begin
      r[b] = (b < 8*n) ? v[b] : top;
    end
    return r;
  endfunction
endpackage

// File: rtl/ldx_classify.sv
module ldx_classify
  import ldx_pkg::*;
(
  input  logic [SIZE_W-1:0] size,
  input  logic              sext,
  input  logic              brev,
  output logic              is_pair,
  output logic              bad,
  output int                nbytes
);
  logic size_ok, sext_ok, brev_ok, half_or_word;

  always_comb begin
    half_or_word = (size == SZ_HALF) || (size == SZ_WORD);
    size_ok      = (size <= SZ_QUAD);
    sext_ok      = !sext || (half_or_word && !brev);
    brev_ok      = !brev || half_or_word || (size == SZ_DWORD);
    bad          = !(size_ok && sext_ok && brev_ok);
    is_pair      = (size == SZ_QUAD) && !bad;
    nbytes       = item_bytes(size);
  end
endmodule

// File: rtl/ldx_shape.sv
module ldx_shape
  import ldx_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  int               nbytes,
  input  logic             sext,
  input  logic             brev,
  output reg_t             value
);
  localparam int SHIFT_W = $clog2(REG_W) + 1;

  reg_t                base_dw;
  reg_t                item;
  logic [SHIFT_W-1:0]  drop_bits;

  always_comb begin
    base_dw   = raw[RAW_W-1 -: REG_W];
    drop_bits = SHIFT_W'(8 * (REG_BYTES - nbytes));
    item      = base_dw >> drop_bits;
    if (nbytes == 0)   value = '0;
    else if (brev)     value = rev_low_bytes(item, nbytes);
    else if (sext)     value = fill_sign(item, nbytes);
    else               value = item;
  end
endmodule

// File: rtl/ldx_qpair.sv
module ldx_qpair
  import ldx_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  logic             le,
  output reg_t             even,
  output reg_t             odd
);
  reg_t at_base, at_next;

  always_comb begin
    at_base = raw[RAW_W-1 -: REG_W];
    at_next = raw[REG_W-1:0];
    if (le) begin
      even = rev_low_bytes(at_next, REG_BYTES);
      odd  = rev_low_bytes(at_base, REG_BYTES);
    end else begin
      even = at_base;
      odd  = at_next;
    end
  end
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
  import ldx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [127:0] in_data,
  input  logic [2:0]   in_size,
  input  logic         in_sext,
  input  logic         in_brev,
  input  logic         in_le,
  output logic         out_vld,
  output logic [63:0]  out_even,
  output logic [63:0]  out_odd,
  output logic         out_pair,
  output logic         out_bad
);
  logic is_pair, is_bad;
  int   nbytes;
  reg_t single_val, q_even, q_odd;
  reg_t nxt_even, nxt_odd;

  ldx_classify u_cls (
    .size(in_size), .sext(in_sext), .brev(in_brev),
    .is_pair(is_pair), .bad(is_bad), .nbytes(nbytes)
  );

  ldx_shape u_shp (
    .raw(in_data), .nbytes(nbytes), .sext(in_sext), .brev(in_brev),
    .value(single_val)
  );

  ldx_qpair u_qp (
    .raw(in_data), .le(in_le), .even(q_even), .odd(q_odd)
  );

  always_comb begin
    if (is_bad) begin
      nxt_even = '0;
      nxt_odd  = '0;
    end else if (is_pair) begin
      nxt_even = q_even;
      nxt_odd  = q_odd;
    end else begin
      nxt_even = single_val;
      nxt_odd  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_even <= '0;
      out_odd  <= '0;
      out_pair <= 1'b0;
      out_bad  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_even <= nxt_even;
        out_odd  <= nxt_odd;
        out_pair <= is_pair;
        out_bad  <= is_bad;
      end
    end
  end

  assert_vld_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_even) && $stable(out_odd)));
  assert_byte_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_size == 3'd0 && !is_bad) |=> (out_even[63:8] == '0));
  assert_zero_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_size == 3'd1 && !in_sext) |=> (out_even[63:16] == '0));
  assert_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_size == 3'd2 && in_sext && !in_brev) |=>
      (out_even[63:31] == '0 || out_even[63:31] == '1));
  assert_single_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_pair) |-> (out_odd == '0));
  assert_bad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad |-> (out_even == '0 && out_odd == '0 && !out_pair));
endmodule

// File: tb/ldx_unit_tb_top.sv
`timescale 1ns/1ps
module ldx_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [127:0] in_data = '0;
  logic [2:0]   in_size = '0;
  logic         in_sext = 1'b0;
  logic         in_brev = 1'b0;
  logic         in_le = 1'b0;
  logic         out_vld, out_pair, out_bad;
  logic [63:0]  out_even, out_odd;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  ldx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_size(in_size), .in_sext(in_sext), .in_brev(in_brev), .in_le(in_le),
    .out_vld(out_vld), .out_even(out_even), .out_odd(out_odd),
    .out_pair(out_pair), .out_bad(out_bad)
  );

  localparam logic [127:0] PAT_POS = 128'h3152_6374_8596_a7b8_c9da_ebfc_0d1e_2f40;
  localparam logic [127:0] PAT_NEG = 128'hf1e2_d3c4_b5a6_9788_7968_5a4b_3c2d_1e0f;

  function automatic logic [7:0] mbyte(input logic [127:0] d, input int k);
    return d[127 - 8*k -: 8];
  endfunction

  // big-endian value built from bytes first..first+n-1
  function automatic logic [63:0] be_val(input logic [127:0] d, input int first, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[55:0], mbyte(d, first + i)};
    return v;
  endfunction

  // value whose most significant byte is at first+n-1
  function automatic logic [63:0] le_val(input logic [127:0] d, input int first, input int n);
    logic [63:0] v = '0;
    for (int i = n - 1; i >= 0; i--) v = {v[55:0], mbyte(d, first + i)};
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] d, input logic [2:0] sz,
                      input logic sx, input logic br, input logic le);
    @(negedge clk);
    in_vld = 1'b1; in_data = d; in_size = sz; in_sext = sx; in_brev = br; in_le = le;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic expect_single(input string req, input logic [63:0] exp);
    check({req, " vld"}, 64'(out_vld), 64'd1);
    check(req, out_even, exp);
    check({req, " odd"}, out_odd, 64'd0);
    check({req, " pair"}, 64'(out_pair), 64'd0);
    check({req, " bad"}, 64'(out_bad), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 reset vld", 64'(out_vld), 64'd0);
    check("R1 reset even", out_even, 64'd0);
    check("R1 reset odd", out_odd, 64'd0);
    check("R1 reset pair", 64'(out_pair), 64'd0);
    check("R1 reset bad", 64'(out_bad), 64'd0);
  endtask

  task automatic t_byte();
    send(PAT_POS, 3'd0, 0, 0, 0); expect_single("R2 byte pos", 64'h31);
    send(PAT_NEG, 3'd0, 0, 0, 0); expect_single("R2 byte neg", 64'hf1);
  endtask

  task automatic t_zero_ext();
    send(PAT_NEG, 3'd1, 0, 0, 0); expect_single("R3 half zero", be_val(PAT_NEG, 0, 2));
    send(PAT_NEG, 3'd2, 0, 0, 0); expect_single("R3 word zero", be_val(PAT_NEG, 0, 4));
  endtask

  task automatic t_sign_ext();
    send(PAT_NEG, 3'd1, 1, 0, 0); expect_single("R4 half neg", {{48{1'b1}}, be_val(PAT_NEG, 0, 2)[15:0]});
    send(PAT_POS, 3'd1, 1, 0, 0); expect_single("R4 half pos", be_val(PAT_POS, 0, 2));
    send(PAT_NEG, 3'd2, 1, 0, 0); expect_single("R4 word neg", {{32{1'b1}}, be_val(PAT_NEG, 0, 4)[31:0]});
    send(PAT_POS, 3'd2, 1, 0, 0); expect_single("R4 word pos", be_val(PAT_POS, 0, 4));
  endtask

  task automatic t_brev();
    send(PAT_NEG, 3'd1, 0, 1, 0); expect_single("R5 half rev", le_val(PAT_NEG, 0, 2));
    send(PAT_NEG, 3'd2, 0, 1, 0); expect_single("R5 word rev", le_val(PAT_NEG, 0, 4));
  endtask

  task automatic t_dword();
    send(PAT_POS, 3'd3, 0, 0, 0); expect_single("R6 dword pass", be_val(PAT_POS, 0, 8));
    send(PAT_POS, 3'd3, 0, 1, 0); expect_single("R6 dword rev", le_val(PAT_POS, 0, 8));
  endtask

  task automatic t_quad(input logic [127:0] d);
    send(d, 3'd4, 0, 0, 0);
    check("R7 quad be even", out_even, be_val(d, 0, 8));
    check("R7 quad be odd", out_odd, be_val(d, 8, 8));
    check("R7 quad be pair", 64'(out_pair), 64'd1);
    send(d, 3'd4, 0, 0, 1);
    check("R8 quad le even", out_even, le_val(d, 8, 8));
    check("R8 quad le odd", out_odd, le_val(d, 0, 8));
    check("R8 quad le pair", 64'(out_pair), 64'd1);
    check("R8 quad le bad", 64'(out_bad), 64'd0);
  endtask

  task automatic t_le_ignored();
    send(PAT_NEG, 3'd2, 1, 0, 1); expect_single("R9 le word", {{32{1'b1}}, be_val(PAT_NEG, 0, 4)[31:0]});
    send(PAT_POS, 3'd3, 0, 0, 1); expect_single("R9 le dword", be_val(PAT_POS, 0, 8));
    send(PAT_POS, 3'd1, 0, 1, 1); expect_single("R9 le half rev", le_val(PAT_POS, 0, 2));
  endtask

  task automatic bad_case(input string req, input logic [2:0] sz, input logic sx, input logic br);
    send(PAT_NEG, 3'd4, 0, 0, 0);
    send(PAT_NEG, sz, sx, br, 0);
    check({req, " bad"}, 64'(out_bad), 64'd1);
    check({req, " even"}, out_even, 64'd0);
    check({req, " odd"}, out_odd, 64'd0);
    check({req, " pair"}, 64'(out_pair), 64'd0);
  endtask

  task automatic t_unsupported();
    bad_case("R10 sext byte", 3'd0, 1, 0);
    bad_case("R10 sext dword", 3'd3, 1, 0);
    bad_case("R10 sext quad", 3'd4, 1, 0);
    bad_case("R10 sext rev half", 3'd1, 1, 1);
    bad_case("R10 sext rev word", 3'd2, 1, 1);
    bad_case("R10 rev byte", 3'd0, 0, 1);
    bad_case("R10 rev quad", 3'd4, 0, 1);
    bad_case("R10 size5", 3'd5, 0, 0);
    bad_case("R10 size7", 3'd7, 0, 0);
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    send(PAT_POS, 3'd3, 0, 0, 0);
    prev = out_even;
    @(negedge clk);
    in_data = PAT_NEG; in_size = 3'd1;
    @(negedge clk);
    check("R1 idle vld", 64'(out_vld), 64'd0);
    check("R1 idle hold", out_even, prev);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_zero_ext();
    t_sign_ext();
    t_brev();
    t_dword();
    t_quad(PAT_POS);
    t_quad(PAT_NEG);
    t_le_ignored();
    t_unsupported();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule